// File: doc/BRIEF.md
# Radix-2² Pipeline Sequencer and Twiddle Multiplier

This block holds the shared sequencing and the twiddle-factor path of a single-path delay-feedback FFT pipeline built from radix-2² stages. One binary counter, log2(N) bits wide, counts valid input samples and wraps modulo N. Each of its bits sets the mode of one butterfly stage, either filling its feedback delay or computing. The same count, offset by the butterfly latency, selects a factor from a fixed-point table of twiddle factors. The factor multiplies the stream that flows from the type-II butterfly into the next type-I butterfly.

The table is built at elaboration from the transform length. A longer transform therefore needs only a wider counter and a larger table. The complex product takes four real multiplies and two adds. It is rounded and saturated back to the sample width and leaves through a single output register.

Top module: `fftTwiddleCtrl`

## Requirements
- R1: The count rises by one on every clock edge with `inValid` high, starts at 0 and wraps from N-1 to 0 (N = 2^LOG2N).
- R2: While `inValid` is low the count does not change, so `bfMode` stays the same.
- R3: `bfMode[s]` equals count bit LOG2N-1-s. Stage s=0 is the first butterfly, with span N/2. A value of 1 means compute and 0 means fill.
- R4: The twiddle exponent is e = n3·k. The index is j = (count − LAT) mod N, n3 = j[LOG2N-3:0] and k = j[LOG2N-1] + 2·j[LOG2N-2].
- R5: The factor is W = (round(S·cos(2πe/N)), −round(S·sin(2πe/N))), with S = 2^(TW-1) − 1. Rounding is to nearest, with halves going up.
- R6: Each output component is (P + 2^(TW-2)) >> (TW-1), where P is the matching part of the exact complex product of the input and W. The shift is arithmetic.
- R7: `outValid` is `inValid` delayed by one clock. The output data loads only on a valid sample and otherwise holds its value.
- R8: After reset the count is 0, and `outValid`, `outRe` and `outIm` are 0.
- R9: A rounded result above 2^(DW-1) − 1 gives 2^(DW-1) − 1. A rounded result below −2^(DW-1) gives −2^(DW-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Valid sample on the input; advances the count |
| inRe | input | DW | Real part of the sample from the type-II butterfly, signed |
| inIm | input | DW | Imaginary part of the same sample, signed |
| outValid | output | 1 | Scaled sample present on the output |
| outRe | output | DW | Real part of the scaled sample, signed |
| outIm | output | DW | Imaginary part of the scaled sample, signed |
| bfMode | output | LOG2N | Fill (0) or compute (1) mode for each butterfly stage |

## Verification
The counter wrap can fall in the same cycle as a sample whose twiddle index still belongs to the tail of the previous frame. This happens because of the latency offset: when the count is below LAT, the index j is still near N. The bench runs valid samples back to back across the wrap and checks every output against exponents from a model that computes j and e from the requirement formulas. It also checks `bfMode` returning to zero. A second overlap is saturation on a sample loaded at the 45° factor, just after gaps in `inValid`. It is judged against the clamp values of R9 and against the hold behaviour.

// File: rtl/fftTwPkg.sv
package fftTwPkg;
  // widest exponent the strobe carries; covers transforms up to 2^16 points
  localparam int TW_EXP_W = 16;

  typedef struct packed {
    logic                sampleEn;
    logic [TW_EXP_W-1:0] twExp;
  } twStrobe_t;
endpackage

// File: rtl/fftTwRom.sv
module fftTwRom #(
  parameter int LOG2N = 6,
  parameter int TW    = 16
) (
  input  logic [LOG2N-1:0]     addr,
  output logic signed [TW-1:0] wRe,
  output logic signed [TW-1:0] wIm
);
  localparam int  N     = 1 << LOG2N;
  localparam real SCALE = (2.0 ** (TW - 1)) - 1.0;
  localparam real TWOPI = 6.283185307179586;

  logic signed [TW-1:0] tabRe [N];
  logic signed [TW-1:0] tabIm [N];

  for (genvar g = 0; g < N; g++) begin : gEntry
    localparam real ANG = TWOPI * real'(g) / real'(N);
    localparam int  CR  = $rtoi($floor(SCALE * $cos(ANG) + 0.5));
    localparam int  CI  = $rtoi($floor(-SCALE * $sin(ANG) + 0.5));
    assign tabRe[g] = TW'(CR);
    assign tabIm[g] = TW'(CI);
  end

  assign wRe = tabRe[addr];
  assign wIm = tabIm[addr];
endmodule

// File: rtl/fftTwCtrl.sv
module fftTwCtrl
  import fftTwPkg::*;
#(
  parameter int LOG2N = 6,
  parameter int LAT   = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output logic [LOG2N-1:0] bfMode,
  output twStrobe_t        strobe
);
  localparam int N      = 1 << LOG2N;
  localparam int EXPMAX = 3 * (N / 4 - 1);

  logic [LOG2N-1:0] cnt;
  logic [LOG2N-1:0] idx;
  logic [LOG2N-3:0] n3;
  logic [1:0]       kDig;
  logic [LOG2N-1:0] expo;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        cnt <= '0;
    else if (inValid) cnt <= cnt + 1'b1;
  end

  // stage 0 (span N/2) follows the top bit, the last stage the bottom bit
  for (genvar s = 0; s < LOG2N; s++) begin : gMode
    assign bfMode[s] = cnt[LOG2N-1-s];
  end

  // index of the sample now at the multiplier, behind the front by LAT
  assign idx  = cnt - LOG2N'(LAT);
  assign n3   = idx[LOG2N-3:0];
  assign kDig = {idx[LOG2N-2], idx[LOG2N-1]};
  assign expo = LOG2N'(n3) * LOG2N'(kDig);

  assign strobe.sampleEn = inValid;
  assign strobe.twExp    = TW_EXP_W'(expo);

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> (cnt == $past(cnt) + 1'b1));                          // R1
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(cnt));                                       // R2
  AST_EXP_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    int'(strobe.twExp) <= EXPMAX);                                    // R4
endmodule

// File: rtl/fftTwPath.sv
module fftTwPath
  import fftTwPkg::*;
#(
  parameter int LOG2N = 6,
  parameter int DW    = 16,
  parameter int TW    = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  twStrobe_t            strobe,
  input  logic signed [DW-1:0] inRe,
  input  logic signed [DW-1:0] inIm,
  output logic                 outValid,
  output logic signed [DW-1:0] outRe,
  output logic signed [DW-1:0] outIm
);
  localparam int PW = DW + TW;
  localparam int SW = PW + 1;
  localparam int SH = TW - 1;
  localparam logic signed [SW-1:0] RND  = SW'(longint'(1) << (SH - 1));
  localparam logic signed [SW-1:0] MAXV = SW'((longint'(1) << (DW - 1)) - 1);
  localparam logic signed [SW-1:0] MINV = ~MAXV;

  logic signed [TW-1:0] wRe, wIm;
  logic                 unusedExpHi;

  assign unusedExpHi = ^strobe.twExp;

  fftTwRom #(.LOG2N(LOG2N), .TW(TW)) rom_i (
    .addr(strobe.twExp[LOG2N-1:0]),
    .wRe (wRe),
    .wIm (wIm)
  );

  logic signed [PW-1:0] pRR, pII, pRI, pIR;
  logic signed [SW-1:0] sumRe, sumIm, shRe, shIm;

  assign pRR = PW'(inRe) * PW'(wRe);
  assign pII = PW'(inIm) * PW'(wIm);
  assign pRI = PW'(inRe) * PW'(wIm);
  assign pIR = PW'(inIm) * PW'(wRe);

  assign sumRe = SW'(pRR) - SW'(pII) + RND;
  assign sumIm = SW'(pRI) + SW'(pIR) + RND;
  assign shRe  = sumRe >>> SH;
  assign shIm  = sumIm >>> SH;

  function automatic logic signed [DW-1:0] clampDw(input logic signed [SW-1:0] v);
    if (v > MAXV)      return MAXV[DW-1:0];
    else if (v < MINV) return MINV[DW-1:0];
    else               return v[DW-1:0];
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outRe    <= '0;
      outIm    <= '0;
    end else begin
      outValid <= strobe.sampleEn;
      if (strobe.sampleEn) begin
        outRe <= clampDw(shRe);
        outIm <= clampDw(shIm);
      end
    end
  end

  AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    strobe.sampleEn |=> outValid);                                    // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.sampleEn |=> (!outValid && $stable(outRe) && $stable(outIm))); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.sampleEn && shRe > MAXV) |=> (outRe == MAXV[DW-1:0]));    // R9
endmodule

// File: rtl/fftTwiddleCtrl.sv
module fftTwiddleCtrl
  import fftTwPkg::*;
#(
  parameter int LOG2N = 6,
  parameter int DW    = 16,
  parameter int TW    = 16,
  parameter int LAT   = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic signed [DW-1:0] inRe,
  input  logic signed [DW-1:0] inIm,
  output logic                 outValid,
  output logic signed [DW-1:0] outRe,
  output logic signed [DW-1:0] outIm,
  output logic [LOG2N-1:0]     bfMode
);
  twStrobe_t strobe;

  fftTwCtrl #(.LOG2N(LOG2N), .LAT(LAT)) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .inValid(inValid),
    .bfMode (bfMode),
    .strobe (strobe)
  );

  fftTwPath #(.LOG2N(LOG2N), .DW(DW), .TW(TW)) path_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .inRe    (inRe),
    .inIm    (inIm),
    .outValid(outValid),
    .outRe   (outRe),
    .outIm   (outIm)
  );
endmodule

// File: tb/fftTwiddleCtrl_tb_top.sv
`timescale 1ns/1ps
module fftTwiddleCtrl_tb_top;
  localparam int LOG2N = 6;
  localparam int N     = 1 << LOG2N;
  localparam int DW    = 16;
  localparam int TW    = 16;
  localparam int LAT   = 3;
  localparam longint DMAX = (longint'(1) << (DW - 1)) - 1;
  localparam longint DMIN = -(longint'(1) << (DW - 1));

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic signed [DW-1:0] inRe = '0;
  logic signed [DW-1:0] inIm = '0;
  logic outValid;
  logic signed [DW-1:0] outRe, outIm;
  logic [LOG2N-1:0] bfMode;

  int nTests = 0;
  int nFail  = 0;
  int bCnt   = 0;
  longint lastRe = 0;
  longint lastIm = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  fftTwiddleCtrl #(.LOG2N(LOG2N), .DW(DW), .TW(TW), .LAT(LAT)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inRe(inRe), .inIm(inIm),
    .outValid(outValid), .outRe(outRe), .outIm(outIm), .bfMode(bfMode)
  );

  task automatic checkEq(input string tag, input longint act, input longint exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int modeOf(input int c);
    int m = 0;
    for (int s = 0; s < LOG2N; s++) m |= ((c >> (LOG2N - 1 - s)) & 1) << s;
    return m;
  endfunction

  function automatic longint rnd(input real x);
    return longint'($rtoi($floor(x + 0.5)));
  endfunction

  // exponent and factor from the count seen at the pipeline front
  task automatic refTw(input int c, output longint wr, output longint wi);
    int j, n3, k, e;
    real s, ang;
    j   = (c - LAT + N) % N;
    n3  = j % (N / 4);
    k   = ((j >> (LOG2N - 1)) & 1) + 2 * ((j >> (LOG2N - 2)) & 1);
    e   = n3 * k;
    s   = (2.0 ** (TW - 1)) - 1.0;
    ang = 6.283185307179586 * real'(e) / real'(N);
    wr  = rnd(s * $cos(ang));
    wi  = rnd(-s * $sin(ang));
  endtask

  function automatic longint scaleDown(input longint p, output bit sat);
    longint r;
    r = (p + (longint'(1) <<< (TW - 2))) >>> (TW - 1);
    sat = 1'b0;
    if (r > DMAX) begin r = DMAX; sat = 1'b1; end
    if (r < DMIN) begin r = DMIN; sat = 1'b1; end
    return r;
  endfunction

  // one cycle: entered at a falling edge, returns at the next falling edge
  task automatic pushOne(input bit v, input longint re, input longint im, input string tag);
    longint wr, wi, er, ei;
    bit sr, si;
    checkEq("R3 mode before sample", bfMode, modeOf(bCnt));
    inValid = v;
    inRe = DW'(re);
    inIm = DW'(im);
    refTw(bCnt, wr, wi);
    er = scaleDown(re * wr - im * wi, sr);
    ei = scaleDown(re * wi + im * wr, si);
    @(negedge clk);
    inValid = 1'b0;
    checkEq("R7 valid follows", outValid, v);
    if (v) begin
      checkEq(sr ? "R9 real clamp" : {tag, " real"}, outRe, er);
      checkEq(si ? "R9 imag clamp" : {tag, " imag"}, outIm, ei);
      lastRe = er;
      lastIm = ei;
      bCnt = (bCnt + 1) % N;
    end else begin
      checkEq("R7 real hold", outRe, lastRe);
      checkEq("R7 imag hold", outIm, lastIm);
      checkEq("R2 mode idle", bfMode, modeOf(bCnt));
    end
  endtask

  task automatic testReset();
    checkEq("R8 outValid", outValid, 0);
    checkEq("R8 outRe", outRe, 0);
    checkEq("R8 outIm", outIm, 0);
    checkEq("R8 count zero", bfMode, 0);
  endtask

  task automatic testTwiddleScan();
    for (int i = 0; i < N; i++) pushOne(1'b1, 16384, 0, "R4 R5 twiddle");
    checkEq("R1 wrap to zero", bfMode, 0);
  endtask

  task automatic testMixedData();
    for (int i = 0; i < N + 8; i++) begin
      longint a = longint'((i * 7919) % 40000) - 20000;
      longint b = longint'((i * 104729) % 50000) - 25000;
      if (i % 5 == 0) begin a = -a; end
      pushOne(1'b1, a, b, "R6 product");
    end
  endtask

  task automatic testGaps();
    for (int i = 0; i < 24; i++) begin
      pushOne(i % 2 == 0, 1000 * i - 9000, 12000 - 700 * i, "R6 gapped");
    end
    pushOne(1'b0, 0, 0, "R7 idle");
    pushOne(1'b0, 0, 0, "R7 idle");
  endtask

  task automatic testSaturation();
    int target = (N / 2 + N / 8 + LAT) % N;
    while (bCnt != target) pushOne(1'b1, 300, -300, "R6 approach");
    pushOne(1'b1, DMAX, DMAX, "R9 positive");
    checkEq("R9 max value", outRe, DMAX);
    pushOne(1'b0, 0, 0, "R7 idle");
    pushOne(1'b1, DMIN, DMIN, "R9 negative");
    checkEq("R9 min value", outRe, DMIN);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testTwiddleScan();
    testMixedData();
    testGaps();
    testSaturation();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule